// File: doc/BRIEF.md
# Monochrome LCD Refresh Engine

This block keeps an 84x48 monochrome graphic panel up to date over a write-only SPI link. The link has a separate line that marks each byte as either a command or display data. The panel controller has two instruction levels. The extended level has to be switched on before bias or contrast writes and switched off again afterwards. The engine hides that protocol from the rest of the chip: a strobe starts a screen refresh, a strobe starts a contrast change, and a strobe starts the power-up programming. The power-up programming also runs by itself after reset.

For a refresh, the engine reads a pixel framebuffer through a read port with one cycle of latency. It takes each column of an 8-row page and packs it into one byte. It sends the six pages in order and sets the controller's RAM address again before every page. The controller RAM is larger than the visible panel, so wrap-around of the column pointer cannot be relied on. A pixel counts as lit when any bit of its stored value is set.

Strobes that arrive while the engine is working are remembered and served later. The order is: power-up first, then contrast, then refresh.

Top module: `mono_lcd_refresh`

## Requirements
- R1: While reset is held, `cs_no` is high and `sclk_o` is low. In the first cycle after reset, `busy_o` is high.
- R2: After reset, the engine sends, as commands (`dc_o` low), 0x21, 0x10|BIAS (0x14 by default), 0x05, 0x40, 0x20, 0x0C. It then sends the default contrast update 0x21, 0xA8, 0x20, which carries the value 40.
- R3: A pulse on `init_req_i` sends the six power-up command bytes of R2 again, and nothing else.
- R4: SPI runs in mode 0 and sends MSB first. Each byte has its own `cs_no` low period, with exactly 8 rising `sclk_o` edges. No `sclk_o` edge occurs while `cs_no` is high. `dc_o` does not change while `cs_no` is low. The first rising edge comes at least one SCLK period after `cs_no` falls.
- R5: A pulse on `contrast_req_i` sends 0x21, then 0x80|(`contrast_i` & 0x7F), then 0x20, all as commands. Bit 7 of `contrast_i` has no effect.
- R6: A pulse on `refresh_req_i` sends pages 0 to 5 in order. Each page consists of the commands 0x80 and 0x40|page, followed by exactly 84 data bytes (`dc_o` high) for columns 0 to 83.
- R7: In a data byte, bit r is 1 exactly when the framebuffer word at row page*8+r of that column is non-zero. Bit 0 is the top row of the page and bit 7 is the bottom row.
- R8: `busy_o` is high from the cycle after an accepted strobe until `cs_no` has returned high after the last byte. Once `busy_o` is low, no SPI activity occurs.
- R9: Strobes that arrive while busy are never dropped. When both are pending, a contrast update is served before a refresh.
- R10: When strobes arrive together, they are served in the order power-up, then contrast, then refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Strobe to resend the power-up programming |
| refresh_req_i | input | 1 | Strobe to send the whole framebuffer |
| contrast_req_i | input | 1 | Strobe to program contrast |
| contrast_i | input | 8 | Contrast value, sampled with its strobe; bit 7 is ignored |
| fb_rd_o | output | 1 | Framebuffer read enable |
| fb_row_o | output | 6 | Framebuffer row address, 0 to 47 |
| fb_col_o | output | 7 | Framebuffer column address, 0 to 83 |
| fb_pix_i | input | 16 | Pixel word, valid the cycle after the read |
| sclk_o | output | 1 | SPI clock, idle low |
| mosi_o | output | 1 | SPI serial data |
| cs_no | output | 1 | SPI chip select, active low |
| dc_o | output | 1 | Low for command bytes, high for display data |
| busy_o | output | 1 | An operation is pending or in progress |

## Verification
A wrong sequencer state shows up at the ports within one byte time. Typical symptoms are a missing or repeated address command, a wrong page index in the second command of a page, or a data byte where a command was expected. A wrong packer bit index or a wrong latency alignment corrupts the data bytes of the first column fetched. A full-frame comparison against arithmetically packed framebuffer contents therefore catches it in the first page. A lost pending flag shows up as a missing operation before `busy_o` falls. A wrong priority shows up as the contrast bytes appearing after the refresh rather than before it.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;
  typedef enum logic [1:0] {OP_INIT, OP_CONTRAST, OP_REFRESH} op_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_FETCH, SQ_DATA} seq_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SETUP, TX_SHIFT, TX_HOLD} tx_e;

  localparam logic [7:0] CMD_EXT_ON   = 8'h21;
  localparam logic [7:0] CMD_EXT_OFF  = 8'h20;
  localparam logic [7:0] CMD_BIAS     = 8'h10;
  localparam logic [7:0] CMD_LINE_HI  = 8'h05;
  localparam logic [7:0] CMD_LINE_LO  = 8'h40;
  localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
  localparam logic [7:0] CMD_COL_ZERO = 8'h80;
  localparam logic [7:0] CMD_PAGE     = 8'h40;
  localparam logic [7:0] CMD_VOLT     = 8'h80;

  function automatic logic [2:0] op_len(op_e op);
    case (op)
      OP_INIT:     return 3'd6;
      OP_CONTRAST: return 3'd3;
      default:     return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
  import lcd_refresh_pkg::*;
#(
  parameter int          PAGE_W = 3,
  parameter logic [2:0]  BIAS   = 3'd4
) (
  input  op_e              op_i,
  input  logic [2:0]       idx_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [7:0]       contrast_i,
  output logic [7:0]       byte_o
);
  always_comb begin
    byte_o = CMD_EXT_OFF;
    unique case (op_i)
      OP_INIT: begin
        case (idx_i)
          3'd0:    byte_o = CMD_EXT_ON;
          3'd1:    byte_o = CMD_BIAS | {5'd0, BIAS};
          3'd2:    byte_o = CMD_LINE_HI;
          3'd3:    byte_o = CMD_LINE_LO;
          3'd4:    byte_o = CMD_EXT_OFF;
          default: byte_o = CMD_DISP_ON;
        endcase
      end
      OP_CONTRAST: begin
        case (idx_i)
          3'd0:    byte_o = CMD_EXT_ON;
          3'd1:    byte_o = CMD_VOLT | contrast_i;
          default: byte_o = CMD_EXT_OFF;
        endcase
      end
      default: begin
        // page addressing: column first, then page row
        byte_o = (idx_i == 3'd0) ? CMD_COL_ZERO : (CMD_PAGE | 8'(page_i));
      end
    endcase
  end
endmodule

// File: rtl/lcd_col_packer.sv
module lcd_col_packer #(
  parameter int COLS   = 84,
  parameter int PAGE_W = 3,
  parameter int COL_W  = 7,
  parameter int PIX_W  = 16,
  parameter int ROWS   = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              fb_rd_o,
  output logic [PAGE_W+2:0] fb_row_o,
  output logic [COL_W-1:0]  fb_col_o,
  input  logic [PIX_W-1:0]  fb_pix_i,
  output logic [7:0]        byte_o,
  output logic              done_o
);
  logic       active_q, rd_v_q, done_q;
  logic [3:0] row_q;
  logic [2:0] rrow_q;
  logic [7:0] acc_q;

  assign fb_rd_o  = active_q && !row_q[3];
  assign fb_row_o = {page_i, row_q[2:0]};
  assign fb_col_o = col_i;
  assign byte_o   = acc_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      row_q    <= '0;
      rd_v_q   <= 1'b0;
      rrow_q   <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      rd_v_q <= fb_rd_o;
      rrow_q <= row_q[2:0];
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        row_q    <= '0;
        acc_q    <= '0;
      end else if (fb_rd_o) begin
        row_q <= row_q + 4'd1;
      end
      if (rd_v_q) begin
        acc_q[rrow_q] <= |fb_pix_i;
        if (rrow_q == 3'd7) begin
          done_q   <= 1'b1;
          active_q <= 1'b0;
        end
      end
    end
  end

  AST_FETCH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> (int'(fb_col_o) < COLS && int'(fb_row_o) < ROWS)); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R7
endmodule

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx
  import lcd_refresh_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       dc_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       cs_no,
  output logic       dc_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(2 * HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] HALF_END  = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(2 * HALF_DIV - 1);

  tx_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;

  assign mosi_o = sh_q[7];
  assign busy_o = (st_q != TX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
      dc_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        TX_IDLE: if (start_i) begin
          cs_no <= 1'b0;
          dc_o  <= dc_i;
          sh_q  <= byte_i;
          cnt_q <= '0;
          bit_q <= '0;
          st_q  <= TX_SETUP;
        end
        TX_SETUP: begin
          // one full SCLK period of select/dc setup
          if (cnt_q == SETUP_END) begin
            cnt_q <= '0;
            st_q  <= TX_SHIFT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        TX_SHIFT: begin
          if (cnt_q == HALF_END) begin
            cnt_q <= '0;
            if (!sclk_o) sclk_o <= 1'b1;
            else begin
              sclk_o <= 1'b0;
              if (bit_q == 3'd7) st_q <= TX_HOLD;
              else begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
              end
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == HALF_END) begin
            cnt_q  <= '0;
            cs_no  <= 1'b1;
            done_o <= 1'b1;
            st_q   <= TX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  AST_SCLK_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R4
  AST_DC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(dc_o)); // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R4
endmodule

// File: rtl/mono_lcd_refresh.sv
module mono_lcd_refresh
  import lcd_refresh_pkg::*;
#(
  parameter int         COLS         = 84,
  parameter int         PAGES        = 6,
  parameter int         PIX_W        = 16,
  parameter int         HALF_DIV     = 4,
  parameter logic [2:0] BIAS         = 3'd4,
  parameter logic [6:0] CONTRAST_RST = 7'd40,
  localparam int        ROWS         = PAGES * 8,
  localparam int        PAGE_W       = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int        ROW_W        = PAGE_W + 3,
  localparam int        COL_W        = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_req_i,
  input  logic             refresh_req_i,
  input  logic             contrast_req_i,
  input  logic [7:0]       contrast_i,
  output logic             fb_rd_o,
  output logic [ROW_W-1:0] fb_row_o,
  output logic [COL_W-1:0] fb_col_o,
  input  logic [PIX_W-1:0] fb_pix_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_no,
  output logic             dc_o,
  output logic             busy_o
);
  seq_e              st_q;
  op_e               op_q;
  logic [2:0]        idx_q;
  logic              sent_q, pk_start_q;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic [7:0]        ctr_q, ctr_cur_q;
  logic              pend_init_q, pend_ctr_q, pend_ref_q;

  logic       take_init, take_ctr, take_ref;
  logic       tx_start, tx_busy, tx_done, pk_done;
  logic [7:0] cmd_byte, pk_byte;

  assign take_init = (st_q == SQ_IDLE) && pend_init_q;
  assign take_ctr  = (st_q == SQ_IDLE) && !pend_init_q && pend_ctr_q;
  assign take_ref  = (st_q == SQ_IDLE) && !pend_init_q && !pend_ctr_q && pend_ref_q;
  assign tx_start  = ((st_q == SQ_CMD) || (st_q == SQ_DATA)) && !sent_q && !tx_busy;
  assign busy_o    = (st_q != SQ_IDLE) || tx_busy || pend_init_q || pend_ctr_q || pend_ref_q;

  lcd_cmd_rom #(.PAGE_W(PAGE_W), .BIAS(BIAS)) i_rom (
    .op_i(op_q), .idx_i(idx_q), .page_i(page_q), .contrast_i(ctr_cur_q), .byte_o(cmd_byte)
  );

  lcd_col_packer #(
    .COLS(COLS), .PAGE_W(PAGE_W), .COL_W(COL_W), .PIX_W(PIX_W), .ROWS(ROWS)
  ) i_pack (
    .clk_i, .rst_ni, .start_i(pk_start_q), .page_i(page_q), .col_i(col_q),
    .fb_rd_o, .fb_row_o, .fb_col_o, .fb_pix_i, .byte_o(pk_byte), .done_o(pk_done)
  );

  lcd_spi_tx #(.HALF_DIV(HALF_DIV)) i_tx (
    .clk_i, .rst_ni, .start_i(tx_start),
    .byte_i((st_q == SQ_DATA) ? pk_byte : cmd_byte), .dc_i(st_q == SQ_DATA),
    .sclk_o, .mosi_o, .cs_no, .dc_o, .busy_o(tx_busy), .done_o(tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_init_q <= 1'b1;
      pend_ctr_q  <= 1'b1;   // default contrast follows power-up
      pend_ref_q  <= 1'b0;
      ctr_q       <= {1'b0, CONTRAST_RST};
      ctr_cur_q   <= '0;
    end else begin
      pend_init_q <= (pend_init_q && !take_init) || init_req_i;
      pend_ctr_q  <= (pend_ctr_q && !take_ctr) || contrast_req_i;
      pend_ref_q  <= (pend_ref_q && !take_ref) || refresh_req_i;
      if (take_ctr) ctr_cur_q <= ctr_q;
      if (contrast_req_i) ctr_q <= contrast_i & 8'h7F;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      op_q       <= OP_INIT;
      idx_q      <= '0;
      sent_q     <= 1'b0;
      pk_start_q <= 1'b0;
      page_q     <= '0;
      col_q      <= '0;
    end else begin
      pk_start_q <= 1'b0;
      if (tx_start) sent_q <= 1'b1;
      if (tx_done)  sent_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          idx_q  <= '0;
          page_q <= '0;
          if (take_init)     begin op_q <= OP_INIT;     st_q <= SQ_CMD; end
          else if (take_ctr) begin op_q <= OP_CONTRAST; st_q <= SQ_CMD; end
          else if (take_ref) begin op_q <= OP_REFRESH;  st_q <= SQ_CMD; end
        end
        SQ_CMD: if (tx_done) begin
          if (idx_q == op_len(op_q) - 3'd1) begin
            if (op_q == OP_REFRESH) begin
              col_q      <= '0;
              pk_start_q <= 1'b1;
              st_q       <= SQ_FETCH;
            end else st_q <= SQ_IDLE;
          end else idx_q <= idx_q + 3'd1;
        end
        SQ_FETCH: if (pk_done) st_q <= SQ_DATA;
        default: if (tx_done) begin
          if (col_q == COL_W'(COLS - 1)) begin
            if (page_q == PAGE_W'(PAGES - 1)) st_q <= SQ_IDLE;
            else begin
              page_q <= page_q + 1'b1;
              idx_q  <= '0;
              st_q   <= SQ_CMD;
            end
          end else begin
            col_q      <= col_q + 1'b1;
            pk_start_q <= 1'b1;
            st_q       <= SQ_FETCH;
          end
        end
      endcase
    end
  end

  AST_BUSY_COVERS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o); // R8
  AST_DATA_ONLY_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && dc_o) |-> (op_q == OP_REFRESH)); // R6
  AST_PAGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(page_q) < PAGES); // R6
  AST_INIT_BEFORE_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == SQ_IDLE) && pend_init_q) |=> (op_q == OP_INIT)); // R10
endmodule

// File: tb/test_mono_lcd_refresh.sv
module test_mono_lcd_refresh;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_req = 1'b0, refresh_req = 1'b0, contrast_req = 1'b0;
  logic [7:0]  contrast = 8'd0;
  logic        fb_rd_o;
  logic [5:0]  fb_row_o;
  logic [6:0]  fb_col_o;
  logic [15:0] fb_pix = '0;
  logic        sclk_o, mosi_o, cs_no, dc_o, busy_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] fb [48][84];
  bit   [8:0]  log_q[$];
  bit   [8:0]  exp_q[$];
  int          nbits = 0;
  logic [7:0]  shreg = '0;
  logic        dc_first = 1'b0;
  time         t_cs_fall = 0;

  always #4 clk = ~clk;

  mono_lcd_refresh #(.HALF_DIV(1)) i_mono_lcd_refresh (
    .clk_i(clk), .rst_ni, .init_req_i(init_req), .refresh_req_i(refresh_req),
    .contrast_req_i(contrast_req), .contrast_i(contrast), .fb_rd_o, .fb_row_o,
    .fb_col_o, .fb_pix_i(fb_pix), .sclk_o, .mosi_o, .cs_no, .dc_o, .busy_o
  );

  always @(posedge clk)
    if (fb_rd_o && fb_row_o < 48 && fb_col_o < 84) fb_pix <= fb[fb_row_o][fb_col_o];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // SPI decoder
  always @(negedge cs_no) t_cs_fall = $time;
  always @(posedge sclk_o) begin
    if (cs_no) chk(1'b0, "R4 sclk while deselected", 1, 0);
    if (nbits == 0) begin
      dc_first = dc_o;
      chk(($time - t_cs_fall) >= 16, "R4 setup before first edge", int'($time - t_cs_fall), 16);
    end else if (dc_o != dc_first) chk(1'b0, "R4 dc changed in frame", dc_o, dc_first);
    shreg = {shreg[6:0], mosi_o};
    nbits++;
    if (nbits == 8) begin
      log_q.push_back({dc_o, shreg});
      nbits = 0;
    end
  end
  always @(posedge cs_no)
    if (rst_ni && nbits != 0) chk(1'b0, "R4 bits per frame", nbits, 8);

  task automatic push(input bit dc, input int b);
    exp_q.push_back({dc, 8'(b)});
  endtask

  task automatic exp_init();
    push(0, 8'h21); push(0, 8'h14); push(0, 8'h05);
    push(0, 8'h40); push(0, 8'h20); push(0, 8'h0C);
  endtask

  task automatic exp_ctr(input int v);
    push(0, 8'h21); push(0, 8'h80 | (v & 8'h7F)); push(0, 8'h20);
  endtask

  task automatic exp_refresh();
    for (int p = 0; p < 6; p++) begin
      push(0, 8'h80);
      push(0, 8'h40 | p);
      for (int c = 0; c < 84; c++) begin
        int b = 0;
        for (int r = 0; r < 8; r++) if (fb[p*8+r][c] != 0) b |= (1 << r);
        push(1, b);
      end
    end
  endtask

  task automatic cmp_log(input string tag);
    int n = (log_q.size() < exp_q.size()) ? log_q.size() : exp_q.size();
    chk(log_q.size() == exp_q.size(), {tag, " byte count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < n; i++)
      chk(log_q[i] == exp_q[i], {tag, " byte"}, int'(log_q[i]), int'(exp_q[i]));
    log_q.delete();
    exp_q.delete();
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o);
  endtask

  task automatic pulse(input bit ini, input bit ctr, input bit ref_, input logic [7:0] v);
    @(negedge clk);
    init_req = ini; contrast_req = ctr; refresh_req = ref_; contrast = v;
    @(negedge clk);
    init_req = 0; contrast_req = 0; refresh_req = 0;
    chk(busy_o == 1'b1, "R8 busy after strobe", busy_o, 1);
  endtask

  task automatic fill(input int mode);
    for (int r = 0; r < 48; r++)
      for (int c = 0; c < 84; c++) begin
        if (mode == 0) begin
          case ($urandom % 4)
            0: fb[r][c] = 16'h0;
            1: fb[r][c] = 16'h1 << ($urandom % 16);
            2: fb[r][c] = 16'($urandom);
            default: fb[r][c] = 16'h0;
          endcase
        end else fb[r][c] = ((r + c) % 3 == 0) ? 16'h8000 : ((r % 5 == 0) ? 16'h0001 : 16'h0);
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill(0);
    repeat (4) @(negedge clk);
    chk(cs_no == 1'b1, "R1 cs in reset", cs_no, 1);
    chk(sclk_o == 1'b0, "R1 sclk in reset", sclk_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R1 busy after reset", busy_o, 1);
    wait_idle();
    exp_init(); exp_ctr(40);
    cmp_log("R2");
    repeat (30) @(negedge clk);
    chk(log_q.size() == 0 && cs_no, "R8 quiet when idle", log_q.size(), 0);

    pulse(0, 1, 0, 8'hFF); wait_idle(); exp_ctr(8'hFF); cmp_log("R5 bit7 ignored");
    pulse(0, 1, 0, 8'h35); wait_idle(); exp_ctr(8'h35); cmp_log("R5");

    pulse(0, 0, 1, 8'h00); wait_idle(); exp_refresh(); cmp_log("R6 R7 random");
    fill(1);
    pulse(0, 0, 1, 8'h00); wait_idle(); exp_refresh(); cmp_log("R7 pattern");
    chk(cs_no == 1'b1, "R8 released at idle", cs_no, 1);

    pulse(1, 0, 0, 8'h00); wait_idle(); exp_init(); cmp_log("R3");

    fill(0);
    pulse(0, 0, 1, 8'h00);
    repeat (300) @(negedge clk);
    pulse(0, 1, 1, 8'h11);
    wait_idle();
    exp_refresh(); exp_ctr(8'h11); exp_refresh();
    cmp_log("R9 queued");

    pulse(1, 1, 1, 8'h7F);
    wait_idle();
    exp_init(); exp_ctr(8'h7F); exp_refresh();
    cmp_log("R10 priority");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule